// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places an incoming byte stream into host-provided receive buffers. The buffers are listed in a circular table of descriptors kept in a RAM that a host processor also reads and writes. Each descriptor is four 16-bit words. The word at offset 0 is the control/status word. The word at offset 2 holds the written-back byte count. Offsets 4 and 6 hold a 32-bit buffer pointer, high half first. The engine reads the control word of the current descriptor and checks its ownership flag. If the engine owns the descriptor, it loads the pointer and streams bytes into the buffer. When the buffer fills or the frame ends, it writes back the count and then the status, which returns the descriptor to the host. It then moves to the next descriptor.

The ring has no length register. A wrap flag in the last descriptor sends the engine back to the table base; any other descriptor is followed by the one eight bytes further on. Each descriptor carries its own interrupt flag. That flag can mask the buffer-complete event, but it never masks the frame-complete event. If the engine meets a descriptor that the host still holds, it discards input bytes, raises a busy event once, and polls until the host hands the descriptor back.

The RAM port is single-ported, with byte enables and a one-cycle read latency. The RAM is big-endian within a word: the byte at an even address sits in bits 15:8. The input stream uses a valid/ready handshake. A frame-end flag and a 5-bit condition vector are sampled with the last byte of a frame.

Top module: `rxbd_ring_engine`

## Requirements
- R1: While reset is held, in_ready, mem_we and all three events are 0. The first RAM read after reset fetches the control word at ring_base.
- R2: A control word with bit 15 = 0 makes the engine accept and drop input bytes without writing the RAM. It pulses ev_busy exactly once per stall, and it resumes once the host sets bit 15.
- R3: Byte k of a buffer is written at byte address P+k. P is the pointer formed from the word at offset 4 (high half) and the word at offset 6 (low half). A write to an even address uses mem_be=2'b10 and lands in bits 15:8; a write to an odd address uses mem_be=2'b01 and lands in bits 7:0.
- R4: When a buffer has received max_len bytes without a frame end, it is closed with count max_len and bit 11 = 0. The frame continues in the next descriptor, where bit 10 = 0.
- R5: When the frame-end byte arrives, the buffer is closed with the count of bytes placed in it and bit 11 = 1. The conditions {brk,ab,cr,ov,cd} from in_flags[4:0] go to bits 7,3,2,1,0, and only on the frame's last descriptor. Frame end takes priority over buffer full.
- R6: The written-back control word has bit 15 = 0. Bits 13, 12 and 9 are copied from the host's word. Bit 10 marks the first buffer of a frame. Bits 14, 8 and 6..4 are 0.
- R7: After a descriptor with bit 13 = 1, the next control read is at ring_base. Otherwise it is at the previous descriptor address + 8.
- R8: Closing a buffer on full pulses ev_rxb only when the descriptor's bit 12 is 1.
- R9: Closing a buffer on frame end pulses ev_rxf whatever bit 12 holds. Both events occur only in the cycle of the control-word write.
- R10: The count word at offset 2 is written in the cycle before the control word at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_eof | input | 1 | Byte is the last of its frame |
| in_flags | input | 5 | Frame conditions {brk,ab,cr,ov,cd}, sampled with in_eof |
| in_ready | output | 1 | Engine takes (stores or drops) the byte this cycle |
| ring_base | input | AW | Byte address of the first descriptor |
| max_len | input | LW | Buffer size in bytes |
| mem_re | output | 1 | RAM read strobe, data valid next cycle |
| mem_we | output | 1 | RAM write strobe |
| mem_be | output | 2 | Byte enables, bit 1 = bits 15:8 |
| mem_addr | output | AW | RAM byte address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data |
| ev_rxb | output | 1 | Buffer-complete event pulse |
| ev_rxf | output | 1 | Frame-complete event pulse |
| ev_busy | output | 1 | Stalled on a host-owned descriptor |

## Verification
A corrupted descriptor cursor shows up within one cycle of a write-back: the next control read lands at the wrong address. A wrong byte counter shows up in the count word, or as buffer bytes at the wrong address, as soon as the buffer closes. A lost first-of-frame or ownership state shows up as a wrong bit 10, or as bytes written into a host-owned buffer, by the next write-back. The scoreboard compares every write-back word, count and event against a queue filled by the stimulus. It compares buffer contents after each phase.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  typedef enum logic [3:0] {
    ST_INIT, ST_RD_CTL, ST_CHK, ST_STALL, ST_RD_PHI,
    ST_RD_PLO, ST_LD_PLO, ST_RUN, ST_WR_LEN, ST_WR_CTL
  } rxbd_state_e;

  // frame condition vector as it arrives with the frame-end byte
  typedef struct packed {
    logic brk;
    logic ab;
    logic cr;
    logic ov;
    logic cd;
  } rx_flags_t;

  localparam int DESC_STRIDE = 8;

  // status word returned to the host (R5, R6)
  function automatic logic [15:0] pack_ctl(input logic w, input logic i,
                                           input logic cm, input logic last,
                                           input logic first, input rx_flags_t f);
    logic [15:0] v;
    v     = '0;
    v[13] = w;
    v[12] = i;
    v[11] = last;
    v[10] = first;
    v[9]  = cm;
    if (last) begin
      v[7] = f.brk;
      v[3] = f.ab;
      v[2] = f.cr;
      v[1] = f.ov;
      v[0] = f.cd;
    end
    return v;
  endfunction

  // R7: ring step
  function automatic logic [31:0] next_desc(input logic [31:0] cur,
                                            input logic [31:0] base,
                                            input logic wrap);
    return wrap ? base : cur + 32'(DESC_STRIDE);
  endfunction

  // R3: byte placement
  function automatic logic [31:0] buf_addr(input logic [31:0] ptr,
                                           input logic [31:0] cnt);
    return ptr + cnt;
  endfunction

endpackage

// File: rtl/rxbd_cursor.sv
module rxbd_cursor import rxbd_pkg::*; #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          advance,
  input  logic          wrap,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] step_addr;

  assign step_addr = AW'(next_desc(32'(cur), 32'(base), wrap));

  always_ff @(posedge clk) begin
    if (!rst_n)       cur <= '0;
    else if (load)    cur <= base;
    else if (advance) cur <= step_addr;
  end
endmodule

// File: rtl/rxbd_fill.sv
module rxbd_fill import rxbd_pkg::*; #(
  parameter int AW = 12,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic [15:0]   rdata,
  input  logic          clr,
  input  logic          take,
  input  logic [LW-1:0] max_len,
  output logic [AW-1:0] wr_addr,
  output logic [LW-1:0] count,
  output logic          full_next
);
  localparam int CW = LW + 1;

  logic [15:0]   ptr_hi;
  logic [31:0]   ptr;
  logic [CW-1:0] cnt_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_hi <= '0;
      ptr    <= '0;
    end else begin
      if (ld_hi) ptr_hi <= rdata;
      if (ld_lo) ptr    <= {ptr_hi, rdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (take) count <= count + 1'b1;
  end

  assign cnt_inc   = {1'b0, count} + CW'(1);
  assign full_next = cnt_inc >= {1'b0, max_len};
  assign wr_addr   = AW'(buf_addr(ptr, 32'(count)));
endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl import rxbd_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_eof,
  input  rx_flags_t   in_flags,
  input  logic        desc_e,
  input  logic        desc_w,
  input  logic        desc_i,
  input  logic        desc_cm,
  input  logic        full_next,
  output rxbd_state_e st,
  output logic        in_ready,
  output logic        take,
  output logic        drop,
  output logic        cur_load,
  output logic        cur_adv,
  output logic        wrap_o,
  output logic        cnt_clr,
  output logic        ph_ld,
  output logic        pl_ld,
  output logic [15:0] ctl_word,
  output logic        ev_rxb,
  output logic        ev_rxf,
  output logic        ev_busy
);
  logic      w_r, i_r, cm_r, eof_r, first_r, busy_r;
  rx_flags_t flags_r;
  logic      close_now;

  assign in_ready  = (st == ST_RUN) || (st == ST_STALL);
  assign take      = (st == ST_RUN) && in_valid;
  assign drop      = (st == ST_STALL) && in_valid;
  assign close_now = take && (in_eof || full_next);
  assign cur_load  = (st == ST_INIT);
  assign cur_adv   = (st == ST_WR_CTL);
  assign wrap_o    = w_r;
  assign ph_ld     = (st == ST_RD_PLO);
  assign pl_ld     = (st == ST_LD_PLO);
  assign cnt_clr   = (st == ST_LD_PLO);
  assign ctl_word  = pack_ctl(w_r, i_r, cm_r, eof_r, first_r, flags_r);
  assign ev_rxb    = (st == ST_WR_CTL) && !eof_r && i_r;
  assign ev_rxf    = (st == ST_WR_CTL) && eof_r;
  assign ev_busy   = (st == ST_CHK) && !desc_e && !busy_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_INIT;
      w_r     <= 1'b0;
      i_r     <= 1'b0;
      cm_r    <= 1'b0;
      eof_r   <= 1'b0;
      first_r <= 1'b1;
      busy_r  <= 1'b0;
      flags_r <= '0;
    end else begin
      case (st)
        ST_INIT:   st <= ST_RD_CTL;
        ST_RD_CTL: st <= ST_CHK;
        ST_CHK: begin
          if (desc_e) begin
            w_r    <= desc_w;
            i_r    <= desc_i;
            cm_r   <= desc_cm;
            busy_r <= 1'b0;
            st     <= ST_RD_PHI;
          end else begin
            busy_r <= 1'b1;
            st     <= ST_STALL;
          end
        end
        ST_STALL: begin
          if (drop && in_eof) first_r <= 1'b1;
          st <= ST_RD_CTL;
        end
        ST_RD_PHI: st <= ST_RD_PLO;
        ST_RD_PLO: st <= ST_LD_PLO;
        ST_LD_PLO: st <= ST_RUN;
        ST_RUN: begin
          if (close_now) begin
            eof_r   <= in_eof;
            flags_r <= in_eof ? in_flags : '0;
            st      <= ST_WR_LEN;
          end
        end
        ST_WR_LEN: st <= ST_WR_CTL;
        ST_WR_CTL: begin
          first_r <= eof_r;
          st      <= ST_RD_CTL;
        end
        default: st <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine import rxbd_pkg::*; #(
  parameter int AW = 12,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eof,
  input  logic [4:0]    in_flags,
  output logic          in_ready,
  input  logic [AW-1:0] ring_base,
  input  logic [LW-1:0] max_len,
  output logic          mem_re,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          ev_rxb,
  output logic          ev_rxf,
  output logic          ev_busy
);
  rxbd_state_e   st;
  logic          take, drop, cur_load, cur_adv, wrap_sel;
  logic          cnt_clr, ph_ld, pl_ld, full_next;
  logic [15:0]   ctl_word;
  logic [AW-1:0] cur, wr_addr;
  logic [LW-1:0] count;

  // named internal events for the checker
  logic stall_drop, ctl_wb, len_wb;
  assign stall_drop = drop;
  assign ctl_wb     = (st == ST_WR_CTL);
  assign len_wb     = (st == ST_WR_LEN);

  rxbd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_eof(in_eof), .in_flags(rx_flags_t'(in_flags)),
    .desc_e(mem_rdata[15]), .desc_w(mem_rdata[13]),
    .desc_i(mem_rdata[12]), .desc_cm(mem_rdata[9]),
    .full_next(full_next), .st(st), .in_ready(in_ready),
    .take(take), .drop(drop), .cur_load(cur_load), .cur_adv(cur_adv),
    .wrap_o(wrap_sel), .cnt_clr(cnt_clr), .ph_ld(ph_ld), .pl_ld(pl_ld),
    .ctl_word(ctl_word), .ev_rxb(ev_rxb), .ev_rxf(ev_rxf), .ev_busy(ev_busy)
  );

  rxbd_cursor #(.AW(AW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(cur_load), .advance(cur_adv),
    .wrap(wrap_sel), .base(ring_base), .cur(cur)
  );

  rxbd_fill #(.AW(AW), .LW(LW)) u_fill (
    .clk(clk), .rst_n(rst_n), .ld_hi(ph_ld), .ld_lo(pl_ld),
    .rdata(mem_rdata), .clr(cnt_clr), .take(take), .max_len(max_len),
    .wr_addr(wr_addr), .count(count), .full_next(full_next)
  );

  // RAM port steering by phase
  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_be    = 2'b00;
    mem_addr  = cur;
    mem_wdata = '0;
    case (st)
      ST_RD_CTL: mem_re = 1'b1;
      ST_RD_PHI: begin
        mem_re   = 1'b1;
        mem_addr = cur + AW'(4);
      end
      ST_RD_PLO: begin
        mem_re   = 1'b1;
        mem_addr = cur + AW'(6);
      end
      ST_RUN: begin
        if (take) begin
          mem_we    = 1'b1;
          mem_addr  = wr_addr;
          mem_be    = wr_addr[0] ? 2'b01 : 2'b10;
          mem_wdata = {in_data, in_data};
        end
      end
      ST_WR_LEN: begin
        mem_we    = 1'b1;
        mem_be    = 2'b11;
        mem_addr  = cur + AW'(2);
        mem_wdata = 16'(count);
      end
      ST_WR_CTL: begin
        mem_we    = 1'b1;
        mem_be    = 2'b11;
        mem_wdata = ctl_word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rxbd_ring_engine_chk.sv
module rxbd_ring_engine_chk #(
  parameter int AW = 12,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_re,
  input logic          mem_we,
  input logic [1:0]    mem_be,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic [AW-1:0] ring_base,
  input logic [LW-1:0] max_len,
  input logic          ev_rxb,
  input logic          ev_rxf,
  input logic          ev_busy,
  input logic          stall_drop,
  input logic          ctl_wb,
  input logic          len_wb
);
  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rxb && ev_rxf)); // R8
  AST_EVT_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rxb || ev_rxf) |-> (ctl_wb && mem_we && mem_be == 2'b11)); // R9
  AST_CTL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wb |-> (!mem_wdata[15] && !mem_wdata[14] && !mem_wdata[8] && mem_wdata[6:4] == 3'b000)); // R6
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_drop |-> !mem_we); // R2
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |=> in_ready); // R2
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (len_wb && max_len != '0) |-> (mem_wdata != 16'd0 && mem_wdata <= 16'(max_len))); // R4
  AST_LEN_THEN_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    len_wb |=> (ctl_wb && mem_addr == $past(mem_addr) - AW'(2))); // R10
  AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wb && mem_wdata[13]) |=> (mem_re && mem_addr == ring_base)); // R7
  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wb && !mem_wdata[13]) |=> (mem_re && mem_addr == $past(mem_addr) + AW'(8))); // R7
endmodule

bind rxbd_ring_engine rxbd_ring_engine_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_re(mem_re),
  .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .ring_base(ring_base), .max_len(max_len),
  .ev_rxb(ev_rxb), .ev_rxf(ev_rxf), .ev_busy(ev_busy),
  .stall_drop(stall_drop), .ctl_wb(ctl_wb), .len_wb(len_wb)
);

// File: tb/rxbd_ring_engine_test.sv
module rxbd_ring_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int LW = 16;
  localparam logic [AW-1:0] BASE = 12'h100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_eof = 1'b0;
  logic [4:0]    in_flags = '0;
  logic          in_ready;
  logic [AW-1:0] ring_base = BASE;
  logic [LW-1:0] max_len = 16'd4;
  logic          mem_re, mem_we;
  logic [1:0]    mem_be;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [15:0]   mem_rdata = '0;
  logic          ev_rxb, ev_rxf, ev_busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbd_ring_engine #(.AW(AW), .LW(LW)) uut (.*);

  // shared RAM model, one-cycle read latency
  logic [15:0] ram [0:(1<<(AW-1))-1];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= ram[mem_addr[AW-1:1]];
    if (mem_we) begin
      if (mem_be[1]) ram[mem_addr[AW-1:1]][15:8] = mem_wdata[15:8];
      if (mem_be[0]) ram[mem_addr[AW-1:1]][7:0]  = mem_wdata[7:0];
    end
  end

  int total = 0, bad = 0, busy_n = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input logic [AW-1:0] a);
    return a[0] ? ram[a[AW-1:1]][7:0] : ram[a[AW-1:1]][15:8];
  endfunction

  task automatic set_desc(input logic [AW-1:0] d, input logic [15:0] ctl, input logic [31:0] p);
    ram[d[AW-1:1]]       = ctl;
    ram[d[AW-1:1] + 1]   = 16'h0;
    ram[d[AW-1:1] + 2]   = p[31:16];
    ram[d[AW-1:1] + 3]   = p[15:0];
  endtask

  typedef struct {
    logic [AW-1:0] addr;
    logic [15:0]   ctl;
    logic [15:0]   len;
    logic          rxb;
    logic          rxf;
  } exp_t;
  exp_t q[$];

  task automatic expect_wb(input logic [AW-1:0] a, input logic [15:0] c,
                           input logic [15:0] l, input logic b, input logic f);
    exp_t e;
    e.addr = a; e.ctl = c; e.len = l; e.rxb = b; e.rxf = f;
    q.push_back(e);
  endtask

  task automatic send(input logic [7:0] b, input logic eof, input logic [4:0] fl);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_eof = eof; in_flags = fl;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_eof = 1'b0; in_flags = '0;
  endtask

  // monitor: scoreboard compare
  logic [15:0]   last_len;
  logic [AW-1:0] last_len_addr;
  bit            first_seen = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_re && !first_seen) begin
        first_seen = 1;
        chk("R1 first control read at base", 32'(mem_addr), 32'(BASE));
      end
      if (ev_busy) busy_n++;
      if (mem_we && mem_be == 2'b11 && mem_addr[2:0] == 3'd2) begin
        last_len = mem_wdata;
        last_len_addr = mem_addr;
      end
      if (mem_we && mem_be == 2'b11 && mem_addr[2:0] == 3'd0) begin
        if (q.size() == 0) chk("R2 unexpected writeback", 32'(mem_addr), 32'hFFFF);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R7 descriptor address", 32'(mem_addr), 32'(e.addr));
          chk("R6 R5 status word", 32'(mem_wdata), 32'(e.ctl));
          chk("R4 R5 byte count", 32'(last_len), 32'(e.len));
          chk("R10 count word first", 32'(last_len_addr), 32'(mem_addr + AW'(2)));
          chk("R8 rxb event", 32'(ev_rxb), 32'(e.rxb));
          chk("R9 rxf event", 32'(ev_rxf), 32'(e.rxf));
        end
      end else if (ev_rxb || ev_rxf) begin
        chk("R9 event outside writeback", 32'({ev_rxb, ev_rxf}), 32'h0);
      end
    end
  end

  task automatic wait_drain();
    while (q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1<<(AW-1)); i++) ram[i] = 16'h0;
    set_desc(12'h100, 16'h9000, 32'h0000_0400); // E, I
    set_desc(12'h108, 16'h8000, 32'h0000_0500); // E
    set_desc(12'h110, 16'hB000, 32'h0000_0600); // E, W, I
    repeat (3) @(negedge clk);
    chk("R1 in_ready in reset", 32'(in_ready), 0);
    chk("R1 mem_we in reset", 32'(mem_we), 0);
    chk("R1 events in reset", 32'({ev_rxb, ev_rxf, ev_busy}), 0);
    rst_n = 1'b1;

    // frame A: 3 bytes, frame end, one buffer
    expect_wb(12'h100, 16'h1C00, 16'd3, 1'b0, 1'b1);
    send(8'h11, 0, '0); send(8'h22, 0, '0); send(8'h33, 1, '0);
    // frame B: 6 bytes over two buffers, crc condition (bit 2)
    expect_wb(12'h108, 16'h0400, 16'd4, 1'b0, 1'b0);
    expect_wb(12'h110, 16'h3804, 16'd2, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) send(8'h40 + 8'(i), i == 5, (i == 5) ? 5'b00100 : 5'b0);
    wait_drain();
    chk("R3 frame A byte 0", 32'(rd_byte(12'h400)), 32'h11);
    chk("R3 frame A byte 2", 32'(rd_byte(12'h402)), 32'h33);
    chk("R3 odd lane byte 1", 32'(ram[12'h400 >> 1][7:0]), 32'h22);
    chk("R4 frame B split tail", 32'(rd_byte(12'h601)), 32'h45);
    chk("R4 frame B head", 32'(rd_byte(12'h503)), 32'h43);

    // frame C lands on a host-owned descriptor: dropped
    send(8'hC0, 0, '0); send(8'hC1, 1, 5'b00010);
    repeat (10) @(negedge clk);
    chk("R2 single busy event", 32'(busy_n), 1);
    chk("R2 dropped byte not stored", 32'(rd_byte(12'h400)), 32'h11);
    chk("R2 dropped byte not stored 1", 32'(rd_byte(12'h401)), 32'h22);

    // host returns all descriptors; desc2 also carries bit 9
    ram[12'h100 >> 1] = 16'h9000;
    ram[12'h108 >> 1] = 16'h9000;
    ram[12'h110 >> 1] = 16'hB200;
    // frame D: full and end together, brk+ab conditions
    expect_wb(12'h100, 16'h1C88, 16'd4, 1'b0, 1'b1);
    for (int i = 0; i < 4; i++) send(8'hD0 + 8'(i), i == 3, (i == 3) ? 5'b11000 : 5'b0);
    // frame E: 5 bytes, first buffer with I=1 raises rxb
    expect_wb(12'h108, 16'h1400, 16'd4, 1'b1, 1'b0);
    expect_wb(12'h110, 16'h3A00, 16'd1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) send(8'hE0 + 8'(i), i == 4, '0);
    wait_drain();
    chk("R3 frame D byte 3", 32'(rd_byte(12'h403)), 32'hD3);
    chk("R3 frame E byte 0", 32'(rd_byte(12'h500)), 32'hE0);
    chk("R4 frame E tail", 32'(rd_byte(12'h600)), 32'hE4);
    chk("R2 busy again after wrap", 32'(busy_n), 2);
    chk("R6 all writebacks seen", 32'(q.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog R2 act=%h exp=%h", q.size(), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule